// File: doc/BRIEF.md
# Ethernet Transmit Descriptor Fetch Engine

This block is the control side of an Ethernet transmitter. It polls one slot of a small on-chip descriptor RAM. When it finds a descriptor marked ready, it works out the frame's limits. It then copies the payload from system memory into a local word buffer, one 32-bit word per cycle. Finally it presents the frame on a valid/ready stream as a length header followed by the data words.

Each frame limit comes from a per-descriptor flag combined with a global mode input:
- The minimum length is the configured floor when padding is requested, either per frame or globally. Otherwise it is the payload length.
- The maximum length is the payload length when oversize frames are allowed. Otherwise it is the configured ceiling.
- A CRC is requested either by the global input or by a frame that asks for it and is also marked last. When a CRC is requested, the header length grows by four bytes.

After the stream completes, the engine returns the status word to the descriptor RAM with the ready flag and the status fields cleared. It then moves on to the next descriptor slot and wraps around the configured ring size. The CRC value itself, line signalling and the receive side live in other blocks.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset the engine is idle: `tx_valid`, `bd_wr_en` and `mem_rd_en` are 0 and `bd_addr` points at descriptor slot 0.
- R2: While `cfg_tx_en` is 0 the engine consumes no descriptor: no stream word appears and a ready descriptor word is left unchanged in the RAM.
- R3: A descriptor is the control word at the current index (length in bits [31:16], ready in bit 15) and the buffer byte address at index+1. While enabled, the engine keeps polling a slot whose ready bit is 0 and starts a frame as soon as the bit is 1.
- R4: `fr_min_len` equals `cfg_min_len` when descriptor bit 12 or `cfg_pad` is set, and equals the payload length otherwise.
- R5: `fr_max_len` equals the payload length when `cfg_huge` is set, and equals `cfg_max_len` otherwise.
- R6: `fr_crc` is 1 when `cfg_crc` is set, or when descriptor bits 11 and 10 are both set. The header word is then payload length + 4; otherwise it is the payload length. The header is zero-extended to 32 bits.
- R7: The payload is read from consecutive word addresses starting at the buffer address, 4 bytes apart. Data word k of the stream equals the memory word at buffer address + 4k.
- R8: The stream carries the header word first, followed by ceil(length/4) data words. `tx_last` is set on the final word, which is the header itself when the length is 0. Each word is held until `tx_ready` is 1.
- R9: After the last word is accepted, the control word is written back with bit 15 and bits [8:0] cleared. Bits [8:0] are the underrun flag, the retry count in [7:4] and the error flags in [3:0]. All other bits are kept.
- R10: The descriptor index advances by 2 after each frame and returns to 0 when it reaches 2×`cfg_bd_count`.
- R11: A payload longer than the buffer (4×BUF_WORDS bytes) is fetched and streamed only up to the buffer size. The header still reports the declared length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | 1 | Global transmit enable |
| cfg_pad | input | 1 | Global pad-to-minimum mode |
| cfg_huge | input | 1 | Global oversize-frame allow |
| cfg_crc | input | 1 | Global CRC append |
| cfg_min_len | input | 16 | Configured minimum frame length |
| cfg_max_len | input | 16 | Configured maximum frame length |
| cfg_bd_count | input | BD_AW | Number of descriptors in the ring |
| bd_addr | output | BD_AW | Descriptor RAM word address |
| bd_rd_data | input | 32 | Descriptor RAM read data (same cycle) |
| bd_wr_en | output | 1 | Descriptor RAM write strobe |
| bd_wr_data | output | 32 | Descriptor RAM write data |
| mem_rd_en | output | 1 | Payload memory read strobe |
| mem_addr | output | 32 | Payload memory byte address |
| mem_rd_data | input | 32 | Payload memory read data (same cycle) |
| tx_valid | output | 1 | Stream word valid |
| tx_data | output | 32 | Stream word |
| tx_last | output | 1 | Final word of the frame |
| tx_ready | input | 1 | Stream consumer ready |
| fr_min_len | output | 16 | Minimum length of the frame being sent |
| fr_max_len | output | 16 | Maximum length of the frame being sent |
| fr_crc | output | 1 | CRC requested for the frame being sent |

## Verification
The hardest case to reach from the ports is the ring wrap. The engine only ever looks at a single slot, so a wrong index shows up as a frame that never starts rather than as a wrong value. The stimulus runs more frames than the ring holds and places each descriptor only in the slot the requirements predict, cycling 0, 2, 4, 0. Any indexing mistake then stalls the frame-start wait and is reported. The other corner cases are a zero-length frame whose header carries the last flag, a payload larger than the buffer, and stalls on the ready input in the middle of a frame.

// File: rtl/tde_pkg.sv
package tde_pkg;
    localparam int unsigned LEN_W      = 16;
    localparam int unsigned LEN_LSB    = 16;
    localparam int unsigned BIT_RDY    = 15;
    localparam int unsigned BIT_PAD    = 12;
    localparam int unsigned BIT_CRC    = 11;
    localparam int unsigned BIT_LAST   = 10;
    localparam logic [31:0] STAT_CLEAR = 32'h0000_81FF;

    typedef enum logic [2:0] {
        S_IDLE, S_POLL, S_PTR, S_FILL, S_SEND, S_WBACK
    } tde_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] min_len;
        logic [LEN_W-1:0] max_len;
        logic             add_crc;
        logic [LEN_W:0]   hdr_len;
    } tde_frame_t;

    function automatic logic [31:0] status_after(input logic [31:0] ctrl);
        return ctrl & ~STAT_CLEAR;
    endfunction
endpackage

// File: rtl/tde_frame_decode.sv
module tde_frame_decode
    import tde_pkg::*;
(
    input  logic [LEN_W-1:0] d_len,
    input  logic             d_pad,
    input  logic             d_crc,
    input  logic             d_last,
    input  logic             mode_pad,
    input  logic             mode_huge,
    input  logic             mode_crc,
    input  logic [LEN_W-1:0] floor_len,
    input  logic [LEN_W-1:0] ceil_len,
    output tde_frame_t       fr
);
    always_comb begin
        fr.len     = d_len;
        fr.min_len = (d_pad || mode_pad) ? floor_len : d_len;
        fr.max_len = mode_huge ? d_len : ceil_len;
        fr.add_crc = mode_crc || (d_crc && d_last);
        fr.hdr_len = {1'b0, d_len} + (fr.add_crc ? (LEN_W+1)'(4) : '0);
    end
endmodule

// File: rtl/tde_word_buf.sv
module tde_word_buf #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [31:0]   rd_data
);
    logic [31:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_idx] <= wr_data;
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine
    import tde_pkg::*;
#(
    parameter int unsigned BD_AW     = 7,
    parameter int unsigned BUF_WORDS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_tx_en,
    input  logic             cfg_pad,
    input  logic             cfg_huge,
    input  logic             cfg_crc,
    input  logic [15:0]      cfg_min_len,
    input  logic [15:0]      cfg_max_len,
    input  logic [BD_AW-1:0] cfg_bd_count,
    output logic [BD_AW-1:0] bd_addr,
    input  logic [31:0]      bd_rd_data,
    output logic             bd_wr_en,
    output logic [31:0]      bd_wr_data,
    output logic             mem_rd_en,
    output logic [31:0]      mem_addr,
    input  logic [31:0]      mem_rd_data,
    output logic             tx_valid,
    output logic [31:0]      tx_data,
    output logic             tx_last,
    input  logic             tx_ready,
    output logic [15:0]      fr_min_len,
    output logic [15:0]      fr_max_len,
    output logic             fr_crc
);
    localparam int unsigned BUF_AW    = $clog2(BUF_WORDS);
    localparam int unsigned BUF_BYTES = BUF_WORDS * 4;
    localparam int unsigned CNT_W     = LEN_W + 1;

    tde_state_e       state;
    logic [BD_AW-1:0] idx;
    logic [31:0]      ctrl_q;
    logic [31:0]      ptr_q;
    tde_frame_t       fr_q, fr_dec;
    logic [CNT_W-1:0] cnt;
    logic [BUF_AW:0]  eidx;
    logic [BUF_AW:0]  eidx_m1;
    logic [CNT_W-1:0] fill_lim, nwords;
    logic [BD_AW:0]   idx_inc;
    logic [BD_AW-1:0] idx_next;
    logic             buf_we;
    logic [31:0]      buf_rd;

    tde_frame_decode u_dec (
        .d_len     (bd_rd_data[LEN_LSB +: LEN_W]),
        .d_pad     (bd_rd_data[BIT_PAD]),
        .d_crc     (bd_rd_data[BIT_CRC]),
        .d_last    (bd_rd_data[BIT_LAST]),
        .mode_pad  (cfg_pad),
        .mode_huge (cfg_huge),
        .mode_crc  (cfg_crc),
        .floor_len (cfg_min_len),
        .ceil_len  (cfg_max_len),
        .fr        (fr_dec)
    );

    // fetch stops at the buffer capacity; header keeps the declared length
    assign fill_lim = ({1'b0, fr_q.len} < CNT_W'(BUF_BYTES)) ? {1'b0, fr_q.len}
                                                             : CNT_W'(BUF_BYTES);
    assign nwords   = (fill_lim + CNT_W'(3)) >> 2;
    assign eidx_m1  = eidx - 1'b1;
    assign idx_inc  = {1'b0, idx} + (BD_AW+1)'(2);
    assign idx_next = (idx_inc >= {cfg_bd_count, 1'b0}) ? '0 : idx_inc[BD_AW-1:0];
    assign buf_we   = (state == S_FILL) && (cnt < fill_lim);

    tde_word_buf #(.DEPTH(BUF_WORDS)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (cnt[BUF_AW+1:2]),
        .wr_data (mem_rd_data),
        .rd_idx  (eidx_m1[BUF_AW-1:0]),
        .rd_data (buf_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            idx    <= '0;
            ctrl_q <= '0;
            ptr_q  <= '0;
            fr_q   <= '0;
            cnt    <= '0;
            eidx   <= '0;
        end else begin
            case (state)
                S_IDLE: if (cfg_tx_en) state <= S_POLL;
                S_POLL: begin
                    if (bd_rd_data[BIT_RDY]) begin
                        ctrl_q <= bd_rd_data;
                        fr_q   <= fr_dec;
                        cnt    <= '0;
                        state  <= S_PTR;
                    end else if (!cfg_tx_en) begin
                        state <= S_IDLE;
                    end
                end
                S_PTR: begin
                    ptr_q <= bd_rd_data;
                    state <= S_FILL;
                end
                S_FILL: begin
                    if (cnt < fill_lim) begin
                        cnt <= cnt + CNT_W'(4);
                    end else begin
                        eidx  <= '0;
                        state <= S_SEND;
                    end
                end
                S_SEND: begin
                    if (tx_ready) begin
                        if (tx_last) state <= S_WBACK;
                        else         eidx  <= eidx + 1'b1;
                    end
                end
                S_WBACK: begin
                    idx   <= idx_next;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bd_addr    = (state == S_PTR) ? idx + BD_AW'(1) : idx;
        bd_wr_en   = (state == S_WBACK);
        bd_wr_data = status_after(ctrl_q);
        mem_rd_en  = buf_we;
        mem_addr   = ptr_q + 32'(cnt);
        tx_valid   = (state == S_SEND);
        tx_data    = (eidx == '0) ? {{(32-LEN_W-1){1'b0}}, fr_q.hdr_len} : buf_rd;
        tx_last    = tx_valid && (CNT_W'(eidx) == nwords);
        fr_min_len = fr_q.min_len;
        fr_max_len = fr_q.max_len;
        fr_crc     = fr_q.add_crc;
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R8
    AST_HDR_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> tx_data[31:LEN_W+1] == '0); // R6
    AST_FETCH_STRIDE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + 32'd4); // R7
    AST_WB_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        bd_wr_en |-> !bd_wr_data[BIT_RDY] && !bd_addr[0]); // R9
    AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (rst)
        bd_wr_en && cfg_bd_count != '0 |=> bd_addr < {cfg_bd_count, 1'b0}); // R10
endmodule

// File: tb/sim_tx_desc_engine.sv
module sim_tx_desc_engine;
    localparam int BD_AW = 7;
    localparam int BUFW  = 16;
    localparam logic [15:0] MINL = 16'd60;
    localparam logic [15:0] MAXL = 16'd1536;

    // [31:16] len, [5] pad_bd [4] crc_bd [3] last_bd [2] cfg_pad [1] cfg_huge [0] cfg_crc
    // [8] expect crc, [7] expect min=cfg, [6] expect max=len
    localparam logic [31:0] VEC [8] = '{
        {16'd8,  7'b0, 3'b000, 6'b000000},
        {16'd12, 7'b0, 3'b010, 6'b100000},
        {16'd20, 7'b0, 3'b010, 6'b000100},
        {16'd16, 7'b0, 3'b000, 6'b010000},
        {16'd16, 7'b0, 3'b100, 6'b011000},
        {16'd24, 7'b0, 3'b000, 6'b001000},
        {16'd7,  7'b0, 3'b100, 6'b000001},
        {16'd32, 7'b0, 3'b001, 6'b000010}
    };

    logic clk = 0, rst = 1;
    logic cfg_tx_en = 0, cfg_pad = 0, cfg_huge = 0, cfg_crc = 0;
    logic [15:0] cfg_min_len = MINL, cfg_max_len = MAXL;
    logic [BD_AW-1:0] cfg_bd_count = 3;
    logic [BD_AW-1:0] bd_addr;
    logic [31:0] bd_rd_data, bd_wr_data, mem_addr, mem_rd_data, tx_data;
    logic bd_wr_en, mem_rd_en, tx_valid, tx_last, tx_ready = 0, fr_crc;
    logic [15:0] fr_min_len, fr_max_len;
    logic [31:0] bdram [2**BD_AW];
    int errs = 0, checks = 0, fk = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h0101_0101) ^ 32'hC3A5_5A3C;
    endfunction

    assign mem_rd_data = mem_word(mem_addr);
    assign bd_rd_data  = bdram[bd_addr];
    always @(posedge clk) if (bd_wr_en) bdram[bd_addr] <= bd_wr_data;

    tx_desc_engine #(.BD_AW(BD_AW), .BUF_WORDS(BUFW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int len, input logic [5:0] fl, input logic [31:0] ptr,
                             input bit stall);
        int slot = (fk % 3) * 2;
        logic [31:0] ctrl, exp_wb;
        int exp_hdr, exp_min, exp_max, nw, n, cyc, mism, waitc;
        bit ecrc, done;
        ecrc    = fl[0] || (fl[4] && fl[3]);
        exp_hdr = len + (ecrc ? 4 : 0);
        exp_min = (fl[5] || fl[2]) ? int'(MINL) : len;
        exp_max = fl[1] ? len : int'(MAXL);
        nw      = (len + 3) / 4;
        if (nw > BUFW) nw = BUFW;
        ctrl = {len[15:0], 16'h0} | 32'h0000_C1A5 | (32'(fl[5]) << 12)
             | (32'(fl[4]) << 11) | (32'(fl[3]) << 10);
        exp_wb = ctrl & ~32'h0000_81FF;
        @(negedge clk);
        cfg_pad = fl[2]; cfg_huge = fl[1]; cfg_crc = fl[0];
        bdram[slot+1] = ptr;
        bdram[slot]   = ctrl;
        waitc = 0;
        while (!tx_valid && waitc < 300) begin @(negedge clk); waitc++; end
        chk("R10 frame started from expected slot", 32'(tx_valid), 32'd1);
        n = 0; cyc = 0; mism = 0; done = 0;
        while (tx_valid && !done && cyc < 2000) begin
            cyc++;
            tx_ready = stall ? cyc[0] : 1'b1;
            if (tx_ready) begin
                if (n == 0) begin
                    chk("R6 header length", tx_data, 32'(exp_hdr));
                    chk("R6 crc flag", 32'(fr_crc), 32'(ecrc));
                    chk("R4 min length", 32'(fr_min_len), 32'(exp_min));
                    chk("R5 max length", 32'(fr_max_len), 32'(exp_max));
                end else if (tx_data !== mem_word(ptr + 32'(4*(n-1)))) mism++;
                if (tx_last) done = 1;
                n++;
            end
            @(negedge clk);
        end
        tx_ready = 0;
        chk("R8 data word count", 32'(n-1), 32'(nw));
        chk("R7 payload mismatches", 32'(mism), 32'd0);
        waitc = 0;
        while (bdram[slot][15] && waitc < 10) begin @(negedge clk); waitc++; end
        chk("R9 written-back status", bdram[slot], exp_wb);
        fk++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2**BD_AW; i++) bdram[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 tx_valid after reset", 32'(tx_valid), 32'd0);
        chk("R1 bd_wr_en after reset", 32'(bd_wr_en), 32'd0);
        chk("R1 mem_rd_en after reset", 32'(mem_rd_en), 32'd0);
        chk("R1 bd_addr after reset", 32'(bd_addr), 32'd0);

        // R3: enabled but no ready descriptor -> keeps polling, nothing sent
        cfg_tx_en = 1;
        begin
            int seen = 0;
            for (int c = 0; c < 20; c++) begin @(negedge clk); if (tx_valid) seen++; end
            chk("R3 no frame while slot not ready", 32'(seen), 32'd0);
            chk("R3 polls slot 0", 32'(bd_addr), 32'd0);
        end

        for (int v = 0; v < 8; v++)
            run_frame(int'(VEC[v][31:16]), VEC[v][5:0], 32'h0000_1000 + 32'(v * 256), v[0]);

        run_frame(0, 6'b000001, 32'h0000_3000, 1'b0);   // R8 header-only frame with last
        run_frame(80, 6'b000000, 32'h0000_2000, 1'b1);  // R11 clamp at buffer size

        // R2: disable, then offer a ready descriptor
        @(negedge clk);
        cfg_tx_en = 0;
        repeat (10) @(negedge clk);
        begin
            int slot = (fk % 3) * 2;
            int seen = 0;
            bdram[slot+1] = 32'h0000_4000;
            bdram[slot]   = 32'h0010_8000;
            for (int c = 0; c < 40; c++) begin @(negedge clk); if (tx_valid) seen++; end
            chk("R2 no stream while disabled", 32'(seen), 32'd0);
            chk("R2 descriptor untouched", bdram[slot], 32'h0010_8000);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule